// File: doc/BRIEF.md
# Translation Fault Classifier with Refill Register Update

This block sits between an address-translation request and the translation lookaside buffer (TLB). On each request it screens the virtual address against the current privilege mode and decides one of three things. The address may be illegal. It may need a TLB lookup. Or it may pass through untranslated. For mapped addresses it takes the result code that the external TLB returns in the same cycle and turns it into an exception cause and an error flag. The error flag tells the handler that a refill is needed.

On any fault the block also builds new values for the two refill registers from the faulting virtual address and the registers' current contents. The page-table context register takes the upper virtual page bits at a fixed position. The entry-high register takes the even/odd page-pair number above its preserved address-space identifier. A refill handler can then use both registers without recomputing anything. All results are registered, so they appear one clock edge after the request.

Top module: `mmu_fault_classifier`

## Requirements
- R1: In user mode (`user_mode`=1), a request with `vaddr` bit 31 set (address above 0x7FFFFFFF) is a bad-address fault, and `lookup_en` stays low in the request cycle.
- R2: A request with `vaddr` below 0x80000000 and `err_level`=0 raises `lookup_en` in the same cycle and is classified by `tlb_res`. The result codes are 0=hit, 1=miss, 2=invalid and 3=dirty.
- R3: A bad-address fault gives `cause`=5 (address error, store) when `is_write`=1 and `cause`=4 (address error, load) when `is_write`=0, with `err_code`=0.
- R4: A miss result gives `cause`=3 (TLB store) for writes and `cause`=2 (TLB load) for reads, with `err_code`=1.
- R5: An invalid result gives the same TLB store or load cause as a miss, with `err_code`=0.
- R6: A dirty result gives `cause`=1 (TLB modified) in both directions, with `err_code`=0.
- R7: On a fault, `context_out` equals (`cur_context` & 0xFF800000) | ((`vaddr` >> 9) & 0x007FFFF0).
- R8: On a fault, `entryhi_out` equals (`cur_entryhi` & 0xFF) | (`vaddr` & 0xFFFFE000).
- R9: In the following cases the request is not looked up and raises no fault: an address below 0x80000000 while `err_level`=1, or an address at or above 0x80000000 outside user mode. In these cases `xlat_valid`=1, `paddr`=`vaddr` and `wr_perm`=1.
- R10: A hit result gives no fault, `xlat_valid`=1, `paddr`=`tlb_paddr` and `wr_perm`=`tlb_dirty`.
- R11: Results appear at the clock edge that samples `req_valid`. `fault` is high for exactly that one cycle. A cycle without a request clears `fault` and `xlat_valid`, and leaves `context_out` and `entryhi_out` unchanged. A request that does not fault also leaves both registers unchanged.
- R12: Reset (`rst_n` low at a clock edge) clears `fault`, `cause`, `err_code`, `xlat_valid`, `paddr`, `wr_perm`, `context_out` and `entryhi_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present this cycle |
| vaddr | input | 32 | Virtual address of the request |
| is_write | input | 1 | 1 for a store access, 0 for a load |
| user_mode | input | 1 | Requester runs in user mode |
| err_level | input | 1 | Error level active: low segment bypasses the TLB |
| lookup_en | output | 1 | TLB lookup needed for this request (combinational) |
| tlb_res | input | 2 | TLB result code: 0 hit, 1 miss, 2 invalid, 3 dirty |
| tlb_paddr | input | 32 | Physical address from the TLB on a hit |
| tlb_dirty | input | 1 | Matched page is writable |
| cur_context | input | 32 | Current page-table context register value |
| cur_entryhi | input | 32 | Current entry-high register value |
| fault | output | 1 | One-cycle fault strobe |
| cause | output | 3 | Exception cause code (0 none, 1 modified, 2 TLB load, 3 TLB store, 4 address load, 5 address store) |
| err_code | output | 1 | Refill indication (set on a miss) |
| xlat_valid | output | 1 | Translation succeeded |
| paddr | output | 32 | Physical address |
| wr_perm | output | 1 | Write permission of the translation |
| context_out | output | 32 | Updated context register |
| entryhi_out | output | 32 | Updated entry-high register |

## Verification
The bench builds the block with its defaults: a 32-bit address, 4 KiB pages, an 8-bit identifier and 4 pad bits in the context register. With these values the register updates reduce to exactly the masks 0xFF800000/0x007FFFF0 and 0xFF/0xFFFFE000. This lets the bench compute expected values from those masks directly. It picks addresses at both edges of the 0x80000000 boundary and addresses that differ only in bit 12 or 13, and it uses register contents full of set bits. These choices expose a wrong slice position, a cleared pad, or a leaked bit.

// File: rtl/mmu_fc_pkg.sv
// Package: shared encodings for the translation fault classifier.
// Assumes the TLB result and the cause codes keep the values listed in the brief.
package mmu_fc_pkg;

    typedef enum logic [1:0] {
        RES_HIT     = 2'd0,
        RES_MISS    = 2'd1,
        RES_INVALID = 2'd2,
        RES_DIRTY   = 2'd3
    } tlb_res_e;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_MODIFIED = 3'd1,
        CAUSE_TLB_LD   = 3'd2,
        CAUSE_TLB_ST   = 3'd3,
        CAUSE_ADDR_LD  = 3'd4,
        CAUSE_ADDR_ST  = 3'd5
    } cause_e;

    typedef struct packed {
        logic   fault;
        cause_e cause;
        logic   err;
        logic   hit;
    } verdict_t;

endpackage

// File: rtl/mmu_addr_screen.sv
// Module: mmu_addr_screen
// Sorts a request address into bad, mapped or pass-through from the privilege
// mode and the error-level flag. Assumes the mapped/unmapped split is the top
// address bit; only that bit is passed in.
module mmu_addr_screen (
    input  logic va_top,
    input  logic user_mode,
    input  logic err_level,
    output logic bad_addr,
    output logic mapped,
    output logic bypass
);
    // Classify the address region for the current mode.
    always_comb begin
        bad_addr = user_mode && va_top;
        mapped   = !va_top && !err_level;
        bypass   = !bad_addr && !mapped;
    end
endmodule

// File: rtl/mmu_cause_map.sv
// Module: mmu_cause_map
// Turns the screening outcome and the TLB result into a fault verdict: cause
// code, refill flag and hit flag. Assumes the TLB result is only meaningful
// when the address is mapped; a bad address takes priority over everything.
module mmu_cause_map
    import mmu_fc_pkg::*;
(
    input  logic     bad_addr,
    input  logic     mapped,
    input  logic     is_write,
    input  tlb_res_e tlb_res,
    output verdict_t verdict
);
    // Pick the load or store flavour of each direction-dependent cause.
    cause_e tlb_dir_cause;
    cause_e addr_dir_cause;

    // Direction-dependent cause selection.
    always_comb begin
        tlb_dir_cause  = is_write ? CAUSE_TLB_ST  : CAUSE_TLB_LD;
        addr_dir_cause = is_write ? CAUSE_ADDR_ST : CAUSE_ADDR_LD;
    end

    // Priority decode: bad address, then TLB result, else no fault.
    always_comb begin
        verdict.fault = 1'b0;
        verdict.cause = CAUSE_NONE;
        verdict.err   = 1'b0;
        verdict.hit   = 1'b0;
        if (bad_addr) begin
            verdict.fault = 1'b1;
            verdict.cause = addr_dir_cause;
        end else if (mapped) begin
            unique case (tlb_res)
                RES_HIT: begin
                    verdict.hit = 1'b1;
                end
                RES_MISS: begin
                    verdict.fault = 1'b1;
                    verdict.cause = tlb_dir_cause;
                    verdict.err   = 1'b1;
                end
                RES_INVALID: begin
                    verdict.fault = 1'b1;
                    verdict.cause = tlb_dir_cause;
                end
                RES_DIRTY: begin
                    verdict.fault = 1'b1;
                    verdict.cause = CAUSE_MODIFIED;
                end
                default: begin
                    verdict.fault = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mmu_refill_regs.sv
// Module: mmu_refill_regs
// Builds next values of the context and entry-high registers from the
// page-pair number of the faulting address. Assumes the page-pair number is
// the address bits above PAGE_BITS and that ASID_W <= PAGE_BITS + 1.
module mmu_refill_regs #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int CTX_PAD   = 4,
    localparam int VPN2_W   = VA_W - PAGE_BITS - 1,
    localparam int KEEP_W   = VA_W - VPN2_W - CTX_PAD,
    localparam int GAP_W    = PAGE_BITS + 1 - ASID_W
) (
    input  logic [VPN2_W-1:0] vpn2,
    input  logic [KEEP_W-1:0] ctx_keep,
    input  logic [ASID_W-1:0] asid,
    output logic [VA_W-1:0]   ctx_next,
    output logic [VA_W-1:0]   ehi_next
);
    // Context: preserved base bits, page-pair number, cleared pad.
    always_comb begin
        ctx_next = {ctx_keep, vpn2, {CTX_PAD{1'b0}}};
    end

    // Entry-high: page-pair number, cleared gap, preserved identifier.
    generate
        if (GAP_W > 0) begin : g_gap
            always_comb begin
                ehi_next = {vpn2, {GAP_W{1'b0}}, asid};
            end
        end else begin : g_nogap
            always_comb begin
                ehi_next = {vpn2, asid};
            end
        end
    endgenerate
endmodule

// File: rtl/mmu_fault_classifier.sv
// Module: mmu_fault_classifier (top)
// Screens a translation request, asks the TLB for mapped addresses, classifies
// the result into a cause and registers the outcome together with updated
// refill registers. Assumes the TLB answers combinationally in the request
// cycle while lookup_en is high.
module mmu_fault_classifier
    import mmu_fc_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int CTX_PAD   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] vaddr,
    input  logic            is_write,
    input  logic            user_mode,
    input  logic            err_level,
    output logic            lookup_en,
    input  logic [1:0]      tlb_res,
    input  logic [VA_W-1:0] tlb_paddr,
    input  logic            tlb_dirty,
    input  logic [VA_W-1:0] cur_context,
    input  logic [VA_W-1:0] cur_entryhi,
    output logic            fault,
    output logic [2:0]      cause,
    output logic            err_code,
    output logic            xlat_valid,
    output logic [VA_W-1:0] paddr,
    output logic            wr_perm,
    output logic [VA_W-1:0] context_out,
    output logic [VA_W-1:0] entryhi_out
);
    localparam int VPN2_W = VA_W - PAGE_BITS - 1;
    localparam int KEEP_W = VA_W - VPN2_W - CTX_PAD;

    logic            bad_addr;
    logic            mapped;
    logic            bypass;
    verdict_t        verdict;
    logic [VA_W-1:0] ctx_next;
    logic [VA_W-1:0] ehi_next;
    logic [VA_W-1:0] pa_next;
    logic            wp_next;

    logic            fault_q;
    cause_e          cause_q;
    logic            err_q;
    logic            xv_q;
    logic [VA_W-1:0] pa_q;
    logic            wp_q;
    logic [VA_W-1:0] ctx_q;
    logic [VA_W-1:0] ehi_q;

    mmu_addr_screen u_screen (
        .va_top    (vaddr[VA_W-1]),
        .user_mode (user_mode),
        .err_level (err_level),
        .bad_addr  (bad_addr),
        .mapped    (mapped),
        .bypass    (bypass)
    );

    mmu_cause_map u_cause (
        .bad_addr (bad_addr),
        .mapped   (mapped),
        .is_write (is_write),
        .tlb_res  (tlb_res_e'(tlb_res)),
        .verdict  (verdict)
    );

    mmu_refill_regs #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .ASID_W    (ASID_W),
        .CTX_PAD   (CTX_PAD)
    ) u_refill (
        .vpn2     (vaddr[VA_W-1:PAGE_BITS+1]),
        .ctx_keep (cur_context[VA_W-1:VA_W-KEEP_W]),
        .asid     (cur_entryhi[ASID_W-1:0]),
        .ctx_next (ctx_next),
        .ehi_next (ehi_next)
    );

    // Request a TLB lookup only for mapped addresses of a live request.
    always_comb begin
        lookup_en = req_valid && mapped;
    end

    // Select the physical address and write permission of a good translation.
    always_comb begin
        pa_next = '0;
        wp_next = 1'b0;
        if (verdict.hit) begin
            pa_next = tlb_paddr;
            wp_next = tlb_dirty;
        end else if (bypass) begin
            pa_next = vaddr;
            wp_next = 1'b1;
        end
    end

    // Register the verdict; one-cycle strobe per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            err_q   <= 1'b0;
            xv_q    <= 1'b0;
            pa_q    <= '0;
            wp_q    <= 1'b0;
        end else if (req_valid) begin
            fault_q <= verdict.fault;
            cause_q <= verdict.cause;
            err_q   <= verdict.err;
            xv_q    <= !verdict.fault;
            pa_q    <= pa_next;
            wp_q    <= wp_next;
        end else begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            err_q   <= 1'b0;
            xv_q    <= 1'b0;
            pa_q    <= '0;
            wp_q    <= 1'b0;
        end
    end

    // Load the refill registers on a fault, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
            ehi_q <= '0;
        end else if (req_valid && verdict.fault) begin
            ctx_q <= ctx_next;
            ehi_q <= ehi_next;
        end
    end

    // Drive the registered outputs.
    always_comb begin
        fault       = fault_q;
        cause       = cause_q;
        err_code    = err_q;
        xlat_valid  = xv_q;
        paddr       = pa_q;
        wr_perm     = wp_q;
        context_out = ctx_q;
        entryhi_out = ehi_q;
    end
endmodule

// File: rtl/mmu_fault_classifier_chk.sv
// Module: mmu_fault_classifier_chk
// Temporal properties of the classifier, attached to every instance by bind.
module mmu_fault_classifier_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] vaddr,
    input logic        is_write,
    input logic        user_mode,
    input logic        err_level,
    input logic        lookup_en,
    input logic [1:0]  tlb_res,
    input logic [31:0] cur_context,
    input logic [31:0] cur_entryhi,
    input logic        fault,
    input logic [2:0]  cause,
    input logic        err_code,
    input logic        xlat_valid,
    input logic [31:0] context_out,
    input logic [31:0] entryhi_out
);
    // R1: user access to the high half never asks the TLB
    p_user_high_no_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && vaddr[31]) |-> !lookup_en);

    // R2: a low address without error level always asks the TLB
    p_low_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vaddr[31] && !err_level) |-> lookup_en);

    // R3: bad address gives the address-error cause of its direction
    p_bad_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && vaddr[31]) |=>
        (fault && cause == ($past(is_write) ? 3'd5 : 3'd4) && !err_code));

    // R4: a miss sets the refill flag
    p_miss_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_en && tlb_res == 2'd1) |=> (fault && err_code));

    // R6: dirty result is the modified cause
    p_dirty_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_en && tlb_res == 2'd3) |=> (fault && cause == 3'd1 && !err_code));

    // R7: context keeps its top bits on a fault
    p_ctx_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && user_mode && vaddr[31]) |=>
        (context_out[31:23] == $past(cur_context[31:23])));

    // R8: entry-high keeps its identifier on a fault
    p_ehi_asid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_en && tlb_res == 2'd1) |=>
        (entryhi_out[7:0] == $past(cur_entryhi[7:0])));

    // R9: error level bypasses the TLB for low addresses
    p_erl_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && err_level && !vaddr[31]) |=> (!fault && xlat_valid));

    // R11: no request, no strobe, registers held
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!fault && !xlat_valid && $stable(context_out) && $stable(entryhi_out)));

    // R11: fault and success are never reported together
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && xlat_valid));
endmodule

bind mmu_fault_classifier mmu_fault_classifier_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .vaddr       (vaddr),
    .is_write    (is_write),
    .user_mode   (user_mode),
    .err_level   (err_level),
    .lookup_en   (lookup_en),
    .tlb_res     (tlb_res),
    .cur_context (cur_context),
    .cur_entryhi (cur_entryhi),
    .fault       (fault),
    .cause       (cause),
    .err_code    (err_code),
    .xlat_valid  (xlat_valid),
    .context_out (context_out),
    .entryhi_out (entryhi_out)
);

// File: tb/mmu_fault_classifier_test.sv
// Bench for mmu_fault_classifier: vector table walk, then directed cases.
module mmu_fault_classifier_test;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic        erl;
        logic [1:0]  res;
        logic        dirty;
        logic        e_lookup;
        logic        e_fault;
        logic [2:0]  e_cause;
        logic        e_err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R10 hit, writable page
        '{32'h0040_1234, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0},
        // R10 hit, read-only page
        '{32'h0040_1234, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0},
        // R1 R3 user load above boundary
        '{32'h8000_0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0},
        // R1 R3 user store at the top
        '{32'hFFFF_F000, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0},
        // R2 R4 kernel load miss just below boundary
        '{32'h7FFF_E123, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1},
        // R4 user store miss
        '{32'h1234_5678, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1},
        // R5 invalid load
        '{32'h2000_3000, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0},
        // R5 invalid store
        '{32'h2000_3000, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0},
        // R6 dirty on load
        '{32'h3000_0FFF, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0},
        // R6 dirty on store
        '{32'h3000_1FFF, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0},
        // R9 error level, kernel
        '{32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
        // R9 error level, user store
        '{32'h7000_0000, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
        // R9 kernel high segment passes through
        '{32'h9000_0000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0},
        // R1 user high address wins over error level
        '{32'h8000_0000, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] vaddr = '0;
    logic        is_write = 1'b0;
    logic        user_mode = 1'b0;
    logic        err_level = 1'b0;
    logic        lookup_en;
    logic [1:0]  tlb_res = '0;
    logic [31:0] tlb_paddr = '0;
    logic        tlb_dirty = 1'b0;
    logic [31:0] cur_context = '0;
    logic [31:0] cur_entryhi = '0;
    logic        fault;
    logic [2:0]  cause;
    logic        err_code;
    logic        xlat_valid;
    logic [31:0] paddr;
    logic        wr_perm;
    logic [31:0] context_out;
    logic [31:0] entryhi_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_ctx = '0;
    logic [31:0] exp_ehi = '0;

    always #4 clk = ~clk;

    mmu_fault_classifier uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .vaddr (vaddr),
        .is_write (is_write), .user_mode (user_mode), .err_level (err_level),
        .lookup_en (lookup_en), .tlb_res (tlb_res), .tlb_paddr (tlb_paddr),
        .tlb_dirty (tlb_dirty), .cur_context (cur_context),
        .cur_entryhi (cur_entryhi), .fault (fault), .cause (cause),
        .err_code (err_code), .xlat_valid (xlat_valid), .paddr (paddr),
        .wr_perm (wr_perm), .context_out (context_out), .entryhi_out (entryhi_out)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk(!fault && cause == 3'd0 && !err_code, "R12", "fault/cause/err", {28'd0, fault, cause}, 32'd0);
        chk(!xlat_valid && paddr == 32'd0 && !wr_perm, "R12", "xlat/paddr", paddr, 32'd0);
        chk(context_out == 32'd0 && entryhi_out == 32'd0, "R12", "refill regs", context_out | entryhi_out, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            @(negedge clk);
            req_valid   = 1'b1;
            vaddr       = v.va;
            is_write    = v.wr;
            user_mode   = v.usr;
            err_level   = v.erl;
            tlb_res     = v.res;
            tlb_dirty   = v.dirty;
            tlb_paddr   = 32'h0ABC_D000 | {20'd0, v.va[11:0]} | (32'(i) << 12);
            cur_context = 32'hFFFF_FFFF ^ (32'(i) << 24);
            cur_entryhi = 32'hDEAD_BE00 | {24'd0, 8'(8'h5A + i)};
            #1;
            chk(lookup_en == v.e_lookup, "R2", $sformatf("lookup v%0d", i), {31'd0, lookup_en}, {31'd0, v.e_lookup});
            if (v.e_fault) begin
                exp_ctx = (cur_context & 32'hFF80_0000) | ((v.va >> 9) & 32'h007F_FFF0);
                exp_ehi = (cur_entryhi & 32'h0000_00FF) | (v.va & 32'hFFFF_E000);
            end
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            chk(fault == v.e_fault, "R11", $sformatf("fault v%0d", i), {31'd0, fault}, {31'd0, v.e_fault});
            chk(cause == v.e_cause, v.e_cause == 3'd1 ? "R6" : (v.e_cause >= 3'd4 ? "R3" : "R4"),
                $sformatf("cause v%0d", i), {29'd0, cause}, {29'd0, v.e_cause});
            chk(err_code == v.e_err, v.e_err ? "R4" : "R5", $sformatf("err v%0d", i), {31'd0, err_code}, {31'd0, v.e_err});
            chk(context_out == exp_ctx, "R7", $sformatf("context v%0d", i), context_out, exp_ctx);
            chk(entryhi_out == exp_ehi, "R8", $sformatf("entryhi v%0d", i), entryhi_out, exp_ehi);
            if (!v.e_fault) begin
                logic [31:0] epa;
                logic        ewp;
                epa = v.e_lookup ? tlb_paddr : v.va;
                ewp = v.e_lookup ? v.dirty : 1'b1;
                chk(xlat_valid, v.e_lookup ? "R10" : "R9", $sformatf("xlat v%0d", i), {31'd0, xlat_valid}, 32'd1);
                chk(paddr == epa, v.e_lookup ? "R10" : "R9", $sformatf("paddr v%0d", i), paddr, epa);
                chk(wr_perm == ewp, v.e_lookup ? "R10" : "R9", $sformatf("wrperm v%0d", i), {31'd0, wr_perm}, {31'd0, ewp});
            end
        end

        // R11 strobe lasts one cycle and idle keeps refill registers
        @(negedge clk);
        chk(!fault && !xlat_valid, "R11", "idle strobe", {30'd0, fault, xlat_valid}, 32'd0);
        chk(context_out == exp_ctx && entryhi_out == exp_ehi, "R11", "idle hold", context_out, exp_ctx);

        // R11 a non-faulting request (hit) leaves refill registers alone
        req_valid = 1'b1; vaddr = 32'h0000_2000; is_write = 1'b0; user_mode = 1'b1;
        err_level = 1'b0; tlb_res = 2'd0; cur_context = 32'h0; cur_entryhi = 32'h0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!fault && context_out == exp_ctx && entryhi_out == exp_ehi, "R11", "hit hold", entryhi_out, exp_ehi);

        // R7 R8 bit 12 versus bit 13 boundary of the page pair
        req_valid = 1'b1; vaddr = 32'h0000_3000; tlb_res = 2'd1;
        cur_context = 32'h007F_FFFF; cur_entryhi = 32'h0000_1FFF;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(context_out == 32'h0000_0010, "R7", "ctx pair bit", context_out, 32'h0000_0010);
        chk(entryhi_out == 32'h0000_20FF, "R8", "ehi pair bit", entryhi_out, 32'h0000_20FF);

        // R12 reset in the middle clears registered state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(context_out == 32'd0 && entryhi_out == 32'd0 && !fault, "R12", "mid reset", context_out, 32'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule